// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block models a byte-wide serial EEPROM that answers as a slave on an I2C-compatible two-wire bus. It oversamples SCL and SDA with the system clock, finds start and stop conditions, and decodes a control byte. The control byte carries a fixed device code, a three-bit chip-select field compared against three strap inputs, and a read/write bit. After a write-type control byte, the master sends a two-byte word address and then any number of data bytes. Data bytes are collected in a page buffer. They reach the storage array only after a stop, during a self-timed write cycle.

Reads return bytes from the address pointer. The pointer advances by one after every byte and wraps at the end of the array. A random read is a write-type control byte plus the word address, then a repeated start and a read-type control byte. While a write cycle runs, the block does not acknowledge its control byte, so the master can poll for completion. A write-protect input blocks every change to the array.

The array is a synchronous RAM whose depth is set by `ADDR_W`. The page size, the write-cycle length in clocks and the synchronizer depth are parameters as well. SDA is open-drain: `sda_oe` high means the block pulls the line low.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The block acknowledges a control byte only when its upper four bits are 1010 and bits 3..1 equal `strap_i[2:0]`. Bit 0 selects read (1) or write (0). For any other control byte, the block leaves SDA released for the acknowledge bit and ignores the bus until the next start.
- R2: The word address arrives high byte first. Address bits at or above `ADDR_W` are ignored, so the location used is the 16-bit word address modulo 2^`ADDR_W`.
- R3: A single data byte written after the word address, followed by a stop, is stored at that address once the write cycle ends.
- R4: In a write, consecutive data bytes go to successive addresses inside the same `PAGE_BYTES`-aligned page. The offset in the page wraps from its last entry to 0. When more than `PAGE_BYTES` bytes are sent, later bytes overwrite earlier ones at the same offset.
- R5: The write cycle starts only on a stop that ends a write with at least one data byte, and it lasts `WRITE_CYCLES` clocks. While it lasts, a control byte that otherwise matches is not acknowledged.
- R6: After a write-type control byte and the word address, a repeated start and a read-type control byte make the block return the byte stored at that address.
- R7: In a read, each byte the master acknowledges is followed by the byte at the next address. The address after the last location of the array is 0.
- R8: A master NACK after a read byte ends the read. The block then leaves SDA released until the next start.
- R9: While `wp_i` is high during the write cycle, no location of the array changes.
- R10: Data bytes followed by a repeated start, with no stop, are discarded and start no write cycle. A stop that directly follows the word address, or the control byte, starts no write cycle.
- R11: After reset, SDA is released and no write cycle is in progress.
- R12: The block changes `sda_oe` only after SCL has fallen. It drives SDA low only during its acknowledge bit and its read-data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (resolved wired-AND) |
| sda_oe | output | 1 | High pulls SDA low; low releases SDA |
| strap_i | input | 3 | Chip-select strap levels compared with control-byte bits 3..1 |
| wp_i | input | 1 | Write protect; high blocks all changes to the array |

## Verification
The bench builds the block with `ADDR_W` = 10, `PAGE_BYTES` = 64 and `WRITE_CYCLES` = 240. The small array means a three-byte read starting two bytes before the end reaches the wrap back to location 0. The short write cycle fits inside one polling control byte. So a poll sent right after a stop must be refused and the next one accepted, which pins down both the busy NACK and the cycle length. The page size stays at 64, so a 70-byte write exercises the in-page wrap and the overwrite of early entries.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  // Fixed device-type code in the top nibble of the control byte
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,   // ignoring the bus until a start
    ST_CTRL,   // shifting in the control byte
    ST_AHI,    // shifting in the high address byte
    ST_ALO,    // shifting in the low address byte
    ST_WDATA,  // shifting in write data
    ST_ACK,    // slave acknowledge bit
    ST_RDATA,  // shifting out read data
    ST_RACK    // master acknowledge after a read byte
  } ee_state_t;

  // True when the control byte targets this device
  function automatic logic ctrl_hit(input logic [7:0] b, input logic [2:0] cs);
    return (b[7:4] == DEV_CODE) && (b[3:1] == cs);
  endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sh, sda_sh;
  logic         scl_q, sda_q;
  logic         scl_s;

  // Both lines pass through the same number of stages so their order is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[TOP-1:0], scl_i};
      sda_sh <= {sda_sh[TOP-1:0], sda_i};
      scl_q  <= scl_sh[TOP];
      sda_q  <= sda_sh[TOP];
    end
  end

  assign scl_s     = scl_sh[TOP];
  assign sda_s     = sda_sh[TOP];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/ee_sync_ram.sv
module ee_sync_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/ee_page_buffer.sv
module ee_page_buffer #(
  parameter int PAW          = 6,
  parameter int DW           = 8,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           ld_en,
  input  logic [PAW-1:0] ld_idx,
  input  logic [DW-1:0]  ld_data,
  input  logic           go,
  input  logic           wp,
  output logic           busy,
  output logic           mem_we,
  output logic [PAW-1:0] mem_idx,
  output logic [DW-1:0]  mem_data
);
  localparam int PAGE = 1 << PAW;
  localparam int CW   = $clog2(WRITE_CYCLES + 1);

  logic [DW-1:0] slot [PAGE];
  logic [PAGE-1:0] vld;
  logic [CW-1:0]   left;
  logic [PAW:0]    cidx;   // top bit set once every slot has been visited

  assign busy = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
      cidx <= '0;
      vld  <= '0;
    end else begin
      if (go && !busy) begin
        left <= CW'(WRITE_CYCLES);
        cidx <= '0;
      end else if (busy) begin
        left <= left - 1'b1;
        if (!cidx[PAW]) cidx <= cidx + 1'b1;
      end
      if (busy && left == CW'(1)) vld <= '0;
      else if (clr && !busy)      vld <= '0;
      else if (ld_en)             vld[ld_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) slot[ld_idx] <= ld_data;
  end

  // One slot per clock during the first PAGE clocks of the cycle
  assign mem_idx  = cidx[PAW-1:0];
  assign mem_data = slot[mem_idx];
  assign mem_we   = busy && !cidx[PAW] && vld[mem_idx] && !wp;

endmodule

// File: rtl/ee_slave_ctrl.sv
module ee_slave_ctrl
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [2:0]        strap_i,
  input  logic              busy,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] ptr,
  output logic              lat_clr,
  output logic              lat_ld,
  output logic [PAW-1:0]    lat_idx,
  output logic [7:0]        lat_data,
  output logic              commit_go,
  output logic              ack_ctrl,
  output logic              drive_phase
);
  ee_state_t   state, ret;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, hi_q;
  logic        drive, pend, ack_ctrl_q, mack;
  logic        byte_done;

  function automatic logic [ADDR_W-1:0] join_addr(input logic [7:0] h, input logic [7:0] l);
    logic [15:0] w;
    w = {h, l};
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] step_in_page(input logic [ADDR_W-1:0] p);
    return {p[ADDR_W-1:PAW], PAW'(p[PAW-1:0] + 1'b1)};
  endfunction

  assign byte_done   = scl_fall && (bitcnt == 4'd8);
  assign lat_ld      = (state == ST_WDATA) && byte_done && !start_evt && !stop_evt;
  assign lat_idx     = ptr[PAW-1:0];
  assign lat_data    = shreg;
  assign lat_clr     = start_evt;
  assign commit_go   = stop_evt && pend;
  assign sda_oe      = drive;
  assign ack_ctrl    = ack_ctrl_q;
  assign drive_phase = (state == ST_ACK) || (state == ST_RDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ret        <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      hi_q       <= '0;
      drive      <= 1'b0;
      ptr        <= '0;
      pend       <= 1'b0;
      ack_ctrl_q <= 1'b0;
      mack       <= 1'b0;
    end else if (start_evt) begin
      state      <= ST_CTRL;
      bitcnt     <= '0;
      drive      <= 1'b0;
      pend       <= 1'b0;
      ack_ctrl_q <= 1'b0;
    end else if (stop_evt) begin
      state      <= ST_IDLE;
      drive      <= 1'b0;
      pend       <= 1'b0;
      ack_ctrl_q <= 1'b0;
    end else begin
      case (state)
        ST_CTRL, ST_AHI, ST_ALO, ST_WDATA: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            bitcnt <= '0;
            case (state)
              ST_CTRL: begin
                if (ctrl_hit(shreg, strap_i) && !busy) begin
                  drive      <= 1'b1;
                  state      <= ST_ACK;
                  ack_ctrl_q <= 1'b1;
                  ret        <= shreg[0] ? ST_RDATA : ST_AHI;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_AHI: begin
                hi_q  <= shreg;
                drive <= 1'b1;
                state <= ST_ACK;
                ret   <= ST_ALO;
              end
              ST_ALO: begin
                ptr   <= join_addr(hi_q, shreg);
                drive <= 1'b1;
                state <= ST_ACK;
                ret   <= ST_WDATA;
              end
              default: begin
                ptr   <= step_in_page(ptr);
                pend  <= 1'b1;
                drive <= 1'b1;
                state <= ST_ACK;
                ret   <= ST_WDATA;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            ack_ctrl_q <= 1'b0;
            bitcnt     <= '0;
            if (ret == ST_RDATA) begin
              shreg <= rd_data;
              drive <= ~rd_data[7];
              ptr   <= ptr + 1'b1;
              state <= ST_RDATA;
            end else begin
              drive <= 1'b0;
              state <= ret;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              drive <= 1'b0;
              state <= ST_RACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              drive <= ~shreg[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (mack) begin
              shreg <= rd_data;
              drive <= ~rd_data[7];
              ptr   <= ptr + 1'b1;
              state <= ST_RDATA;
            end else begin
              drive <= 1'b0;
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W       = 11,      // 7..15; array depth is 2**ADDR_W
  parameter int PAGE_BYTES   = 64,      // power of two, at most WRITE_CYCLES
  parameter int WRITE_CYCLES = 500000,  // write-cycle length in clocks
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int PAW = $clog2(PAGE_BYTES);

  // Named internal events, visible to the bound checker
  logic              sda_s, scl_rise_evt, scl_fall_evt, start_evt, stop_evt;
  logic              busy, ack_ctrl, drive_phase, commit_go;
  logic              lat_clr, lat_ld;
  logic [PAW-1:0]    lat_idx, mem_idx;
  logic [7:0]        lat_data, mem_data, rd_data;
  logic              mem_we;
  logic [ADDR_W-1:0] ptr, mem_waddr;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise_evt), .scl_fall(scl_fall_evt),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  ee_slave_ctrl #(.ADDR_W(ADDR_W), .PAW(PAW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise_evt), .scl_fall(scl_fall_evt),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .strap_i(strap_i), .busy(busy), .rd_data(rd_data),
    .sda_oe(sda_oe), .ptr(ptr),
    .lat_clr(lat_clr), .lat_ld(lat_ld), .lat_idx(lat_idx), .lat_data(lat_data),
    .commit_go(commit_go), .ack_ctrl(ack_ctrl), .drive_phase(drive_phase)
  );

  ee_page_buffer #(.PAW(PAW), .DW(8), .WRITE_CYCLES(WRITE_CYCLES)) u_page (
    .clk(clk), .rst_n(rst_n), .clr(lat_clr), .ld_en(lat_ld),
    .ld_idx(lat_idx), .ld_data(lat_data), .go(commit_go), .wp(wp_i),
    .busy(busy), .mem_we(mem_we), .mem_idx(mem_idx), .mem_data(mem_data)
  );

  // The pointer's page bits cannot move during the cycle: control bytes are refused
  assign mem_waddr = {ptr[ADDR_W-1:PAW], mem_idx};

  ee_sync_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_data),
    .raddr(ptr), .rdata(rd_data)
  );

endmodule

// File: rtl/ee_slave_chk.sv
module ee_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_fall_evt,
  input logic start_evt,
  input logic stop_evt,
  input logic busy,
  input logic ack_ctrl,
  input logic mem_we,
  input logic drive_phase,
  input logic wp_i
);
  // R12
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> drive_phase);

  // R12
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall_evt || start_evt || stop_evt));

  // R12
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, scl_fall_evt}));

  // R5
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ctrl |-> !busy);

  // R5
  cycle_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));

  // R9
  wp_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && !wp_i));

endmodule

bind i2c_eeprom_slave ee_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall_evt(scl_fall_evt),
  .start_evt(start_evt), .stop_evt(stop_evt), .busy(busy), .ack_ctrl(ack_ctrl),
  .mem_we(mem_we), .drive_phase(drive_phase), .wp_i(wp_i)
);

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
  localparam int AW    = 10;
  localparam int SPAN  = 1 << AW;
  localparam int WC    = 240;
  localparam int Q     = 6;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, wp = 1'b0;
  logic sda_oe;
  wire  sda;
  assign sda = ~(m_low | sda_oe);
  always #4 clk = ~clk;

  i2c_eeprom_slave #(.ADDR_W(AW), .PAGE_BYTES(64), .WRITE_CYCLES(WC), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .strap_i(STRAP), .wp_i(wp)
  );

  int n_run = 0, n_fail = 0, edge_bad = 0;
  logic [7:0] mdl [SPAN];
  bit         known [SPAN];
  logic [7:0] wbuf [80];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R12 monitor: the slave's drive must not move while the bench holds SCL high
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe !== prev_oe)) edge_bad++;
    prev_oe <= sda_oe;
  end

  task automatic bus_start();
    m_low = 0; wq(Q); scl = 1; wq(Q); m_low = 1; wq(Q); scl = 0; wq(Q);
  endtask

  task automatic bus_stop();
    m_low = 1; wq(Q); scl = 1; wq(Q); m_low = 0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wq(Q); scl = 1; wq(Q); scl = 0; wq(Q);
    end
    m_low = 0; wq(Q); scl = 1; wq(Q / 2);
    ack = (sda == 1'b0);
    wq(Q / 2); scl = 0; wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      scl = 1; wq(Q / 2); b[i] = sda; wq(Q / 2); scl = 0; wq(Q);
    end
    m_low = give_ack; wq(Q); scl = 1; wq(Q); scl = 0; wq(Q); m_low = 0;
  endtask

  function automatic logic [7:0] ctl(input bit rd, input logic [2:0] cs);
    return {4'b1010, cs, rd};
  endfunction

  // Location of the i-th byte of a write that starts at a (wraps inside 64-byte page)
  function automatic int page_loc(input int a, input int i);
    int b;
    b = a % SPAN;
    return (b / 64) * 64 + ((b % 64) + i) % 64;
  endfunction

  task automatic wr_block(input int a16, input int n, input string req);
    bit ack;
    bus_start();
    send_byte(ctl(0, STRAP), ack); chk(ack, req, ack, 1);
    send_byte(a16[15:8], ack);     chk(ack, req, ack, 1);
    send_byte(a16[7:0], ack);      chk(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack); chk(ack, req, ack, 1);
      if (!wp) begin
        mdl[page_loc(a16, i)]   = wbuf[i];
        known[page_loc(a16, i)] = 1'b1;
      end
    end
    bus_stop();
  endtask

  task automatic wait_ready(output int polls);
    bit ack;
    polls = 0;
    do begin
      bus_start();
      send_byte(ctl(0, STRAP), ack);
      bus_stop();
      polls++;
    end while (!ack && polls < 20);
  endtask

  task automatic rd_block(input int a, input int n, input string req);
    bit ack;
    logic [7:0] b;
    int loc;
    bus_start();
    send_byte(ctl(0, STRAP), ack);  chk(ack, req, ack, 1);
    send_byte(8'(a >> 8), ack);     chk(ack, req, ack, 1);
    send_byte(8'(a), ack);          chk(ack, req, ack, 1);
    bus_start();
    send_byte(ctl(1, STRAP), ack);  chk(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      loc = (a + i) % SPAN;
      if (known[loc]) chk(b === mdl[loc], req, b, mdl[loc]);
    end
    // R8: after the NACK an extra SCL pulse must find SDA released
    scl = 1; wq(Q / 2);
    chk(sda === 1'b1, "R8", sda, 1);
    wq(Q / 2); scl = 0; wq(Q);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int polls;
    bit ack;
    logic [7:0] b;
    void'($urandom(32'd7321));
    for (int i = 0; i < SPAN; i++) known[i] = 1'b0;

    // R11 reset state
    wq(5);
    chk(sda === 1'b1, "R11", sda, 1);
    rst_n = 1; wq(5);
    chk(sda === 1'b1 && sda_oe === 1'b0, "R11", sda_oe, 0);
    // R11: not busy, a matching control byte is accepted at once
    bus_start(); send_byte(ctl(0, STRAP), ack); bus_stop();
    chk(ack, "R11", ack, 1);

    // R1: wrong strap, wrong device code
    bus_start(); send_byte(ctl(0, 3'b100), ack); bus_stop();
    chk(!ack, "R1", ack, 0);
    bus_start(); send_byte({4'b1011, STRAP, 1'b0}, ack); bus_stop();
    chk(!ack, "R1", ack, 0);
    bus_start(); send_byte(ctl(1, 3'b001), ack); bus_stop();
    chk(!ack, "R1", ack, 0);

    // R3 byte write, R5 polling: first poll refused, second accepted
    wbuf[0] = 8'hA5;
    wr_block(16'h0123, 1, "R3");
    wait_ready(polls);
    chk(polls == 2, "R5", polls, 2);
    rd_block(16'h0123, 1, "R3");

    // R2: address bits above the array width are ignored
    wbuf[0] = 8'h3C;
    wr_block(16'hFC05, 1, "R2");
    wait_ready(polls);
    rd_block(16'h0005, 1, "R2");

    // R10: repeated start discards latched data; stop after address starts no cycle
    bus_start();
    send_byte(ctl(0, STRAP), ack); send_byte(8'h01, ack); send_byte(8'h23, ack);
    send_byte(8'h77, ack);
    bus_start();
    send_byte(ctl(0, STRAP), ack);
    chk(ack, "R10", ack, 1);
    bus_stop();
    wait_ready(polls);
    chk(polls == 1, "R10", polls, 1);
    rd_block(16'h0123, 1, "R10");

    // R4: 70 bytes starting at offset 60 of page 0x080
    for (int i = 0; i < 70; i++) wbuf[i] = 8'(i * 3 + 17);
    wr_block(16'h00BC, 70, "R4");
    wait_ready(polls);
    rd_block(16'h0080, 64, "R4");

    // R7: sequential read across the end of the array
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    wr_block(SPAN - 2, 2, "R7");
    wait_ready(polls);
    wbuf[0] = 8'h5E;
    wr_block(16'h0000, 1, "R7");
    wait_ready(polls);
    rd_block(SPAN - 2, 3, "R7");

    // R9: write protect keeps the old contents
    wp = 1;
    wbuf[0] = 8'h99;
    wr_block(16'h0123, 1, "R9");
    wait_ready(polls);
    wp = 0;
    chk(known[16'h0123] && mdl[16'h0123] == 8'hA5, "R9", mdl[16'h0123], 8'hA5);
    rd_block(16'h0123, 1, "R9");

    // R6: random writes and random reads
    for (int it = 0; it < 6; it++) begin
      int a, n;
      a = $urandom_range(0, SPAN - 1);
      n = $urandom_range(1, 20);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_block(a, n, "R4");
      wait_ready(polls);
      chk(polls == 2, "R5", polls, 2);
      rd_block(a, n, "R6");
    end

    // R12: drive never moved while SCL was high
    chk(edge_bad == 0, "R12", edge_bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule